// File: doc/BRIEF.md
# Streaming Associative Road Matcher

The block holds a bank of stored track patterns. Each pattern lists one coarse hit address, a super-strip, for every detector layer. Hits arrive as a stream of super-strip words. Each word carries a layer tag, and each layer closes its own part of the event with an end marker. Every incoming super-strip is compared against all stored patterns in the same cycle. Any pattern that holds that super-strip on that layer records a layer hit. Matching therefore happens while the event is still loading, and no separate search pass follows.

When the last layer has sent its end marker, the block stops accepting hits. Each pattern whose count of hit layers has reached the threshold on `match_thresh` counts as a fired road. Fired roads leave one per handshake in ascending pattern index, and a closing end word follows them. Accepting that end word clears all layer hits, and the block is ready for the next event. Patterns are written one layer entry at a time through a plain write port, and only while no event is open.

Both streams are valid/ready. The hit input can be stalled: `hit_ready` stays low from the cycle after the last end marker until the closing word has been taken. On the road output, a word held with `road_valid` high stays unchanged until `road_ready` accepts it.

Top module: `assoc_road_matcher`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hit_ready` is 1, `road_valid` is 0 and `cfg_err` is 0. All stored super-strips and layer hits start at zero.
- R2: A write with `cfg_we` high while no event is open stores `cfg_ss` as the super-strip of pattern `cfg_pat` on layer `cfg_layer`. A write while an event is open (from the first accepted hit word until the closing word is accepted) leaves the bank unchanged and sets `cfg_err`, which stays 1 until reset.
- R3: An accepted hit word with `hit_eoe`=0 marks layer `hit_layer` as hit in every pattern whose stored super-strip for that layer equals `hit_ss`, all in the same cycle. A hit word for a layer whose end marker has already been accepted has no effect. Repeated hits on one layer count once.
- R4: An accepted word with `hit_eoe`=1 closes layer `hit_layer`, and its `hit_ss` is ignored. Once all layers are closed, `hit_ready` is 0 and `road_valid` is 1 from the next cycle until the closing word is accepted. No road is ever offered while any layer is still open.
- R5: A pattern fires when its number of hit layers is greater than or equal to `match_thresh`, taken in the cycle the last end marker is accepted. With 8 every layer must match, and with 7 one layer may be missing.
- R6: Fired roads are offered with `road_eoe`=0 and `road_idx` equal to the pattern index, in strictly ascending index order, one per cycle in which `road_valid` and `road_ready` are both 1. While `road_ready` is 0 the offered word stays unchanged.
- R7: After the last road, the block offers a closing word with `road_eoe`=1 and `road_idx`=0. An event in which no pattern fires offers only the closing word.
- R8: Accepting the closing word clears all layer hits and closed-layer marks. `hit_ready` is 1 in the next cycle, and the next event depends only on its own hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Pattern write strobe |
| cfg_pat | input | PIDX_W (4) | Pattern index to write |
| cfg_layer | input | LYR_W (3) | Layer of the entry to write |
| cfg_ss | input | SS_W (8) | Super-strip value to store |
| cfg_err | output | 1 | Sticky flag: a write was attempted during an event |
| match_thresh | input | CNT_W (4) | Minimum number of hit layers for a road to fire |
| hit_valid | input | 1 | Hit word valid |
| hit_ready | output | 1 | Hit word accepted when high together with hit_valid |
| hit_layer | input | LYR_W (3) | Layer tag of the hit word |
| hit_ss | input | SS_W (8) | Super-strip of the hit word |
| hit_eoe | input | 1 | 1 marks the end of the tagged layer for this event |
| road_valid | output | 1 | Road word valid |
| road_ready | input | 1 | Consumer accepts the road word |
| road_idx | output | PIDX_W (4) | Fired pattern index, 0 in the closing word |
| road_eoe | output | 1 | 1 marks the closing word of the event |

## Verification
The bench runs one stimulus under both an 8-layer and a 7-layer threshold. It holds two fully matching patterns and one pattern that misses a single layer, so the run shows whether the threshold is compared inclusively. A no-match event checks that only a closing word comes out. A zero threshold fires every pattern under random back-pressure, which checks both the ascending order and that a stalled word stays put. A further event sends hits after a layer's end marker, sends repeated hits and tries a bank write mid-event. A following event shows that the stale hits and the refused write left no trace.

// File: rtl/arm_pkg.sv
package arm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DRAIN   = 2'd2
  } arm_state_e;
endpackage

// File: rtl/arm_pattern_bank.sv
module arm_pattern_bank #(
  parameter int NPAT   = 16,
  parameter int NLYR   = 8,
  parameter int SS_W   = 8,
  parameter int PIDX_W = 4,
  parameter int LYR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_pat,
  input  logic [LYR_W-1:0]  wr_layer,
  input  logic [SS_W-1:0]   wr_ss,
  input  logic [LYR_W-1:0]  cmp_layer,
  input  logic [SS_W-1:0]   cmp_ss,
  output logic [NPAT-1:0]   cmp_hit
);
  for (genvar g = 0; g < NPAT; g++) begin : g_row
    logic [NLYR-1:0][SS_W-1:0] row;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row <= '0;
      end else if (wr_en && (wr_pat == PIDX_W'(g))) begin
        row[wr_layer] <= wr_ss;
      end
    end

    // broadcast compare: every row sees the same super-strip
    assign cmp_hit[g] = (row[cmp_layer] == cmp_ss);
  end
endmodule

// File: rtl/arm_layer_flags.sv
module arm_layer_flags #(
  parameter int NPAT  = 16,
  parameter int NLYR  = 8,
  parameter int LYR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [LYR_W-1:0] set_layer,
  input  logic [NPAT-1:0]  hit_vec,
  input  logic             clr,
  input  logic [CNT_W-1:0] thresh,
  output logic [NPAT-1:0]  fired
);
  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    logic [NLYR-1:0] flg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg <= '0;
      end else if (clr) begin
        flg <= '0;
      end else if (set_en && hit_vec[g]) begin
        flg[set_layer] <= 1'b1;
      end
    end

    assign fired[g] = ($countones(flg) >= int'(thresh));
  end
endmodule

// File: rtl/arm_road_emitter.sv
module arm_road_emitter #(
  parameter int NPAT   = 16,
  parameter int PIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NPAT-1:0]   fired,
  input  logic              offer,
  input  logic              take,
  output logic [PIDX_W-1:0] idx,
  output logic              last,
  output logic              done
);
  logic [NPAT-1:0] pend;

  always_comb begin
    idx = '0;
    for (int i = NPAT - 1; i >= 0; i--) begin
      if (pend[i]) idx = PIDX_W'(i);
    end
  end

  assign last = ~|pend;
  assign done = offer && take && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (load) begin
      pend <= fired;
    end else if (offer && take && !last) begin
      pend <= pend & (pend - NPAT'(1));
    end
  end
endmodule

// File: rtl/assoc_road_matcher.sv
module assoc_road_matcher #(
  parameter int NPAT   = 16,
  parameter int NLYR   = 8,
  parameter int SS_W   = 8,
  parameter int PIDX_W = $clog2(NPAT),
  parameter int LYR_W  = $clog2(NLYR),
  parameter int CNT_W  = $clog2(NLYR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PIDX_W-1:0] cfg_pat,
  input  logic [LYR_W-1:0]  cfg_layer,
  input  logic [SS_W-1:0]   cfg_ss,
  output logic              cfg_err,
  input  logic [CNT_W-1:0]  match_thresh,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic [LYR_W-1:0]  hit_layer,
  input  logic [SS_W-1:0]   hit_ss,
  input  logic              hit_eoe,
  output logic              road_valid,
  input  logic              road_ready,
  output logic [PIDX_W-1:0] road_idx,
  output logic              road_eoe
);
  import arm_pkg::*;

  arm_state_e      state;
  logic [NLYR-1:0] closed;
  logic [NLYR-1:0] closed_nxt;
  logic [NLYR-1:0] lyr_bit;
  logic            hit_take;
  logic            hit_set;
  logic            last_end;
  logic            cfg_ok;
  logic            cfg_bad;
  logic [NPAT-1:0] cmp_hit;
  logic [NPAT-1:0] fired;
  logic [PIDX_W-1:0] enc_idx;
  logic            pend_empty;
  logic            ev_done;

  assign lyr_bit    = NLYR'(1) << hit_layer;
  assign hit_ready  = (state != ST_DRAIN);
  assign hit_take   = hit_valid && hit_ready;
  assign hit_set    = hit_take && !hit_eoe && !(|(closed & lyr_bit));
  assign closed_nxt = closed | ((hit_take && hit_eoe) ? lyr_bit : '0);
  assign last_end   = hit_take && hit_eoe && (&closed_nxt);
  assign cfg_ok     = cfg_we && (state == ST_IDLE);
  assign cfg_bad    = cfg_we && (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      closed  <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_bad) cfg_err <= 1'b1;
      if (ev_done) closed <= '0;
      else         closed <= closed_nxt;
      unique case (state)
        ST_IDLE: begin
          if (last_end)      state <= ST_DRAIN;
          else if (hit_take) state <= ST_COLLECT;
        end
        ST_COLLECT: if (last_end) state <= ST_DRAIN;
        ST_DRAIN:   if (ev_done)  state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  arm_pattern_bank #(
    .NPAT(NPAT), .NLYR(NLYR), .SS_W(SS_W), .PIDX_W(PIDX_W), .LYR_W(LYR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_ok), .wr_pat(cfg_pat), .wr_layer(cfg_layer), .wr_ss(cfg_ss),
    .cmp_layer(hit_layer), .cmp_ss(hit_ss), .cmp_hit(cmp_hit)
  );

  arm_layer_flags #(
    .NPAT(NPAT), .NLYR(NLYR), .LYR_W(LYR_W), .CNT_W(CNT_W)
  ) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_en(hit_set), .set_layer(hit_layer), .hit_vec(cmp_hit),
    .clr(ev_done), .thresh(match_thresh), .fired(fired)
  );

  arm_road_emitter #(
    .NPAT(NPAT), .PIDX_W(PIDX_W)
  ) u_emit (
    .clk(clk), .rst_n(rst_n),
    .load(last_end), .fired(fired),
    .offer(road_valid), .take(road_ready),
    .idx(enc_idx), .last(pend_empty), .done(ev_done)
  );

  assign road_valid = (state == ST_DRAIN);
  assign road_eoe   = pend_empty;
  assign road_idx   = pend_empty ? '0 : enc_idx;
endmodule

// File: rtl/arm_chk.sv
module arm_chk #(
  parameter int PIDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_err,
  input logic              hit_ready,
  input logic              road_valid,
  input logic              road_ready,
  input logic [PIDX_W-1:0] road_idx,
  input logic              road_eoe
);
  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_ready && road_valid));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && !road_ready) |=> (road_valid && $stable(road_idx) && $stable(road_eoe)));

  // R6
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && road_ready && !road_eoe) |=> (road_valid && (road_eoe || (road_idx > $past(road_idx)))));

  // R7
  close_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && road_eoe) |-> (road_idx == '0));

  // R8
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && road_ready && road_eoe) |=> (hit_ready && !road_valid));
endmodule

bind assoc_road_matcher arm_chk #(.PIDX_W(PIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_err(cfg_err), .hit_ready(hit_ready),
  .road_valid(road_valid), .road_ready(road_ready), .road_idx(road_idx),
  .road_eoe(road_eoe)
);

// File: tb/tb_assoc_road_matcher.sv
module tb_assoc_road_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NL = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_pat = '0;
  logic [2:0] cfg_layer = '0;
  logic [7:0] cfg_ss = '0;
  logic       cfg_err;
  logic [3:0] match_thresh = 4'd8;
  logic       hit_valid = 1'b0;
  logic       hit_ready;
  logic [2:0] hit_layer = '0;
  logic [7:0] hit_ss = '0;
  logic       hit_eoe = 1'b0;
  logic       road_valid;
  logic       road_ready = 1'b1;
  logic [3:0] road_idx;
  logic       road_eoe;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;
  int bp_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_road_matcher dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pat(cfg_pat),
    .cfg_layer(cfg_layer), .cfg_ss(cfg_ss), .cfg_err(cfg_err),
    .match_thresh(match_thresh), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_layer(hit_layer), .hit_ss(hit_ss), .hit_eoe(hit_eoe),
    .road_valid(road_valid), .road_ready(road_ready), .road_idx(road_idx),
    .road_eoe(road_eoe)
  );

  // behavioural reference model
  int m_pat [NP][NL];
  bit m_flag [NP][NL];
  bit m_done [NL];
  int m_pend [$];
  int m_state = 0;   // 0 idle, 1 collecting, 2 draining
  bit m_err = 0;
  int st0;
  int cnt;
  bit all_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pat[p, l]) begin m_pat[p][l] = 0; m_flag[p][l] = 0; end
      foreach (m_done[l]) m_done[l] = 0;
      m_pend = {};
      m_state = 0;
      m_err = 0;
    end else begin
      st0 = m_state;
      if (hit_valid && st0 != 2) begin
        if (m_state == 0) m_state = 1;
        if (hit_eoe) m_done[hit_layer] = 1;
        else if (!m_done[hit_layer]) begin
          for (int p = 0; p < NP; p++)
            if (m_pat[p][hit_layer] == int'(hit_ss)) m_flag[p][hit_layer] = 1;
        end
        all_done = 1;
        foreach (m_done[l]) if (!m_done[l]) all_done = 0;
        if (hit_eoe && all_done) begin
          m_pend = {};
          for (int p = 0; p < NP; p++) begin
            cnt = 0;
            for (int l = 0; l < NL; l++) cnt += int'(m_flag[p][l]);
            if (cnt >= int'(match_thresh)) m_pend.push_back(p);
          end
          m_state = 2;
        end
      end
      if (cfg_we) begin
        if (st0 == 0) m_pat[cfg_pat][cfg_layer] = int'(cfg_ss);
        else m_err = 1;
      end
      if (st0 == 2 && road_ready) begin
        if (m_pend.size() > 0) void'(m_pend.pop_front());
        else begin
          foreach (m_flag[p, l]) m_flag[p][l] = 0;
          foreach (m_done[l]) m_done[l] = 0;
          m_state = 0;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  bit exp_rv, exp_eoe;
  int exp_idx;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_rv  = (m_state == 2);
      exp_eoe = exp_rv && (m_pend.size() == 0);
      exp_idx = (exp_rv && m_pend.size() > 0) ? m_pend[0] : 0;
      vectors++;
      if (hit_ready !== (m_state != 2)) begin
        misses++; $display("FAIL R4 hit_ready act=%b exp=%b t=%0t", hit_ready, (m_state != 2), $time);
      end
      if (road_valid !== exp_rv) begin
        misses++; $display("FAIL R4 road_valid act=%b exp=%b t=%0t", road_valid, exp_rv, $time);
      end
      if (exp_rv && road_eoe !== exp_eoe) begin
        misses++; $display("FAIL R7 road_eoe act=%b exp=%b t=%0t", road_eoe, exp_eoe, $time);
      end
      if (exp_rv && int'(road_idx) != exp_idx) begin
        misses++; $display("FAIL R6 road_idx act=%0d exp=%0d t=%0t", road_idx, exp_idx, $time);
      end
      if (cfg_err !== m_err) begin
        misses++; $display("FAIL R2 cfg_err act=%b exp=%b t=%0t", cfg_err, m_err, $time);
      end
    end
  end

  // consumer back-pressure
  logic [7:0] lfsr = 8'hA5;
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      road_ready = (bp_mode == 0) ? 1'b1 : lfsr[0];
    end
  end

  function automatic int ss_of(int p, int l);
    return (p * 8 + l * 3 + 1) & 255;
  endfunction

  task automatic wr(input int p, input int l, input int ss);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pat = 4'(p); cfg_layer = 3'(l); cfg_ss = 8'(ss);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int l, input int ss, input bit e);
    @(negedge clk);
    hit_valid = 1'b1; hit_layer = 3'(l); hit_ss = 8'(ss); hit_eoe = e;
    while (!hit_ready) @(negedge clk);
    @(posedge clk);
    #1 hit_valid = 1'b0;
  endtask

  task automatic close_all();
    for (int l = NL - 1; l >= 0; l--) send(l, 8'hFF, 1'b1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_state != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  // stimulus for the threshold events: patterns 3 and 10 complete, 5 misses layer 6
  task automatic event_three();
    for (int l = 0; l < NL; l++) begin
      send(l, ss_of(3, l), 1'b0);
      send(l, ss_of(10, l), 1'b0);
      if (l != 6) send(l, ss_of(5, l), 1'b0);
      else        send(l, 8'hFE, 1'b0);
    end
    close_all();
    wait_idle();
  endtask

  initial begin
    // R1: reset state
    #2;
    vectors++;
    if (hit_ready !== 1'b1 || road_valid !== 1'b0 || cfg_err !== 1'b0) begin
      misses++; $display("FAIL R1 reset act=%b%b%b exp=100", hit_ready, road_valid, cfg_err);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: load the bank while idle
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++) wr(p, l, ss_of(p, l));
    // R5 threshold 8: roads 3 and 10 (R3 broadcast, R6 order)
    match_thresh = 4'd8;
    event_three();
    // R5 threshold 7 with back-pressure: roads 3, 5, 10 (R6 hold)
    match_thresh = 4'd7;
    bp_mode = 1;
    event_three();
    // R7: no pattern fires, closing word only
    for (int l = 0; l < NL; l++) send(l, 8'hFF, 1'b0);
    close_all();
    wait_idle();
    // R3: stale hit after layer end, duplicates; R2: write mid-event refused
    match_thresh = 4'd8;
    send(0, 8'hFF, 1'b1);
    send(0, ss_of(0, 0), 1'b0);
    for (int l = 1; l < NL; l++) begin
      send(l, ss_of(0, l), 1'b0);
      send(l, ss_of(0, l), 1'b0);
    end
    wr(0, 1, 8'hEE);
    for (int l = NL - 1; l >= 1; l--) send(l, 8'hFF, 1'b1);
    wait_idle();
    // R8: pattern 0 still intact and previous flags cleared
    for (int l = 0; l < NL; l++) send(l, ss_of(0, l), 1'b0);
    close_all();
    wait_idle();
    // R6: threshold 0 fires every pattern, ascending under back-pressure
    match_thresh = 4'd0;
    close_all();
    wait_idle();
    bp_mode = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end
endmodule